// File: doc/BRIEF.md
# Floating-point status field controller

This block keeps a bank of four floating-point status fields and one global trap-enable vector. Each field holds 7 control bits and 6 sticky flag bits. Field 0 is the main field; fields 1 to 3 act as alternates that speculative code can record events into. Flag bit i and trap-enable bit i refer to the same exception.

One operation is accepted on each clock. The operation works on the field chosen by the field index. A check-flags operation compares the chosen field with the main field and the trap enables. If code that ran speculatively must be redone, the block raises a one-cycle recovery pulse. A set-controls operation rewrites the chosen field's controls with an AND mask and then an OR mask. A clear-flags operation zeroes the chosen field's flags.

A separate sticky-update port ORs event bits into the flags of any field, in the way an arithmetic unit reports raised exceptions. All fields and the trap vector are visible on flat read ports.

Top module: `fp_status_ctrl`

## Requirements
- R1: While rst_ni is low, every flag bit is 0, every field's controls equal CTL_RST (default 7'h46), trap_o equals TRAP_RST (default 6'h15) and recover_o is 0.
- R2: op_i = 2'b01 (check-flags) on field s drives recover_o high in the cycle after the operation when any flag bit i of field s is set together with trap-enable bit i.
- R3: Check-flags on field s also drives recover_o high in the cycle after the operation when any flag bit of field s is set while the same bit of field 0 is clear.
- R4: When neither the R2 condition nor the R3 condition holds, check-flags leaves recover_o low. Check-flags never alters any field's controls or flags.
- R5: op_i = 2'b10 (set-controls) on field s sets that field's controls to (old AND and_mask_i) OR or_mask_i on the next edge. All other controls and all flags are left unchanged.
- R6: op_i = 2'b11 (clear-flags) on field s zeroes that field's 6 flag bits on the next edge. All controls and the flags of other fields are left unchanged.
- R7: When upd_valid_i is high, the bits of upd_flags_i are ORed into the flags of field upd_sel_i on the next edge, and already-set flags stay set.
- R8: When clear-flags and a sticky update target the same field in the same cycle, the clear wins and the flags become 0. When they target different fields, both take effect.
- R9: recover_o is high for at most one cycle, and only in the cycle directly after a check-flags operation. op_i = 2'b00 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation: 00 none, 01 check-flags, 10 set-controls, 11 clear-flags |
| sel_i | input | 2 | Field the operation acts on (0 = main field) |
| and_mask_i | input | 7 | AND mask for set-controls |
| or_mask_i | input | 7 | OR mask for set-controls |
| upd_valid_i | input | 1 | Sticky flag update strobe |
| upd_sel_i | input | 2 | Field receiving the sticky update |
| upd_flags_i | input | 6 | Event bits to OR into the flags |
| recover_o | output | 1 | Registered one-cycle recovery-branch pulse |
| ctl_o | output | 28 | Controls of all fields; field f at bits [7f+6:7f] |
| flg_o | output | 24 | Flags of all fields; field f at bits [6f+5:6f] |
| trap_o | output | 6 | Trap-enable vector |

## Verification
The assertions check on every cycle that set-controls gives the masked value and that clear-flags leaves zeros even when a sticky update hits the same field. They also check that a sticky update never loses bits outside a clear, that check-flags writes no state, and that a recovery pulse is always caused by a check in the cycle before. Only the bench scenarios can show that the pulse has the right value. The bench sweeps every pairing of alternate and main flag patterns against the trap enables, and it also covers the reset constants and the mask results over a full sweep of AND masks.

// File: rtl/fpsf_pkg.sv
package fpsf_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int CTL_W      = 7;
  localparam int FLG_W      = 6;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_CHECK = 2'b01,
    OP_SETC  = 2'b10,
    OP_CLRF  = 2'b11
  } op_e;
endpackage

// File: rtl/fpsf_field.sv
module fpsf_field #(
  parameter int            CW      = 7,
  parameter int            FW      = 6,
  parameter logic [CW-1:0] CTL_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [CW-1:0] and_i,
  input  logic [CW-1:0] or_i,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [FW-1:0] upd_bits_i,
  output logic [CW-1:0] ctl_o,
  output logic [FW-1:0] flg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= CTL_RST;
      flg_o <= '0;
    end else begin
      if (set_i) ctl_o <= (ctl_o & and_i) | or_i;
      // clear outranks a concurrent sticky update
      if (clr_i)      flg_o <= '0;
      else if (upd_i) flg_o <= flg_o | upd_bits_i;
    end
  end
endmodule

// File: rtl/fpsf_check.sv
module fpsf_check #(
  parameter int FW = 6
) (
  input  logic [FW-1:0] alt_i,
  input  logic [FW-1:0] main_i,
  input  logic [FW-1:0] trap_i,
  output logic          fire_o
);
  logic trap_hit, new_evt;
  always_comb begin
    trap_hit = |(alt_i & trap_i);
    new_evt  = |(alt_i & ~main_i);
    fire_o   = trap_hit | new_evt;
  end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fpsf_pkg::*;
#(
  parameter logic [CTL_W-1:0] CTL_RST  = 7'h46,
  parameter logic [FLG_W-1:0] TRAP_RST = 6'h15
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  op_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [CTL_W-1:0]            and_mask_i,
  input  logic [CTL_W-1:0]            or_mask_i,
  input  logic                        upd_valid_i,
  input  logic [SEL_W-1:0]            upd_sel_i,
  input  logic [FLG_W-1:0]            upd_flags_i,
  output logic                        recover_o,
  output logic [NUM_FIELDS*CTL_W-1:0] ctl_o,
  output logic [NUM_FIELDS*FLG_W-1:0] flg_o,
  output logic [FLG_W-1:0]            trap_o
);
  op_e              op;
  logic [FLG_W-1:0] flg_arr [NUM_FIELDS];
  logic [FLG_W-1:0] alt_flg;
  logic             fire;

  assign op = op_e'(op_i);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic sel_hit, upd_hit;
    assign sel_hit = (sel_i == SEL_W'(g));
    assign upd_hit = upd_valid_i && (upd_sel_i == SEL_W'(g));

    fpsf_field #(
      .CW     (CTL_W),
      .FW     (FLG_W),
      .CTL_RST(CTL_RST)
    ) u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (sel_hit && op == OP_SETC),
      .and_i     (and_mask_i),
      .or_i      (or_mask_i),
      .clr_i     (sel_hit && op == OP_CLRF),
      .upd_i     (upd_hit),
      .upd_bits_i(upd_flags_i),
      .ctl_o     (ctl_o[g*CTL_W +: CTL_W]),
      .flg_o     (flg_o[g*FLG_W +: FLG_W])
    );
    assign flg_arr[g] = flg_o[g*FLG_W +: FLG_W];
  end

  assign alt_flg = flg_arr[sel_i];

  fpsf_check #(.FW(FLG_W)) u_check (
    .alt_i (alt_flg),
    .main_i(flg_arr[0]),
    .trap_i(trap_o),
    .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o    <= TRAP_RST;
      recover_o <= 1'b0;
    end else begin
      trap_o    <= trap_o;
      recover_o <= (op == OP_CHECK) && fire;
    end
  end
endmodule

// File: rtl/fpsf_chk.sv
module fpsf_chk
  import fpsf_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  op_i,
  input logic [SEL_W-1:0]            sel_i,
  input logic [CTL_W-1:0]            and_mask_i,
  input logic [CTL_W-1:0]            or_mask_i,
  input logic                        upd_valid_i,
  input logic [SEL_W-1:0]            upd_sel_i,
  input logic [FLG_W-1:0]            upd_flags_i,
  input logic                        recover_o,
  input logic [NUM_FIELDS*CTL_W-1:0] ctl_o,
  input logic [NUM_FIELDS*FLG_W-1:0] flg_o,
  input logic [FLG_W-1:0]            trap_o
);
  function automatic logic [CTL_W-1:0] ctl_at(input logic [NUM_FIELDS*CTL_W-1:0] v,
                                               input logic [SEL_W-1:0] s);
    return v[s*CTL_W +: CTL_W];
  endfunction

  function automatic logic [FLG_W-1:0] flg_at(input logic [NUM_FIELDS*FLG_W-1:0] v,
                                               input logic [SEL_W-1:0] s);
    return v[s*FLG_W +: FLG_W];
  endfunction

  AST_SETC_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b10 |=> ctl_at(ctl_o, $past(sel_i)) ==
      ((ctl_at($past(ctl_o), $past(sel_i)) & $past(and_mask_i)) | $past(or_mask_i))); // R5

  AST_CLRF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |=> flg_at(flg_o, $past(sel_i)) == '0); // R8

  AST_STICKY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !(op_i == 2'b11 && sel_i == upd_sel_i)) |=>
      (flg_at(flg_o, $past(upd_sel_i)) & $past(upd_flags_i)) == $past(upd_flags_i)); // R7

  AST_CHECK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && !upd_valid_i) |=> $stable(ctl_o) && $stable(flg_o)); // R4

  AST_RECOVER_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> $past(op_i) == 2'b01); // R9

  AST_NONE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b00 && !upd_valid_i) |=> $stable(ctl_o) && $stable(flg_o)); // R9
endmodule

bind fp_status_ctrl fpsf_chk u_chk (.*);

// File: tb/fp_status_ctrl_tb.sv
module fp_status_ctrl_tb;
  import fpsf_pkg::*;

  localparam logic [6:0] CR = 7'h46;
  localparam logic [5:0] TR = 6'h15;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [1:0]  sel_i = '0;
  logic [6:0]  and_mask_i = '0, or_mask_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [1:0]  upd_sel_i = '0;
  logic [5:0]  upd_flags_i = '0;
  logic        recover_o;
  logic [27:0] ctl_o;
  logic [23:0] flg_o;
  logic [5:0]  trap_o;

  int n_chk = 0, n_bad = 0;
  logic [6:0] ctl_m [4];
  logic [5:0] flg_m [4];

  always #4 clk = ~clk;

  fp_status_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .sel_i(sel_i),
    .and_mask_i(and_mask_i), .or_mask_i(or_mask_i),
    .upd_valid_i(upd_valid_i), .upd_sel_i(upd_sel_i), .upd_flags_i(upd_flags_i),
    .recover_o(recover_o), .ctl_o(ctl_o), .flg_o(flg_o), .trap_o(trap_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    for (int f = 0; f < 4; f++) begin
      chk(req, 32'(ctl_o[f*7 +: 7]), 32'(ctl_m[f]));
      chk(req, 32'(flg_o[f*6 +: 6]), 32'(flg_m[f]));
    end
  endtask

  // called at a negedge; returns at the next negedge with results visible
  task automatic step(input logic [1:0] op, input logic [1:0] sel,
                      input logic [6:0] am, input logic [6:0] om,
                      input logic uv, input logic [1:0] us, input logic [5:0] uf);
    op_i = op; sel_i = sel; and_mask_i = am; or_mask_i = om;
    upd_valid_i = uv; upd_sel_i = us; upd_flags_i = uf;
    if (op == 2'b10) ctl_m[sel] = (ctl_m[sel] & am) | om;
    if (uv && !(op == 2'b11 && us == sel)) flg_m[us] = flg_m[us] | uf;
    if (op == 2'b11) flg_m[sel] = '0;
    @(negedge clk);
    op_i = 2'b00; upd_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int f = 0; f < 4; f++) begin ctl_m[f] = CR; flg_m[f] = '0; end
    repeat (2) @(negedge clk);
    compare_all("R1");
    chk("R1", 32'(trap_o), 32'(TR));
    chk("R1", 32'(recover_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7: sticky accumulation on every field
    for (int f = 0; f < 4; f++) begin
      step(2'b00, 2'(f), '0, '0, 1'b1, 2'(f), 6'h01);
      step(2'b00, 2'(f), '0, '0, 1'b1, 2'(f), 6'h22);
      compare_all("R7");
    end
    // R9: idle op changes nothing
    step(2'b00, 2'd2, 7'h00, 7'h7f, 1'b0, '0, '0);
    compare_all("R9");
    chk("R9", 32'(recover_o), 0);

    // R6: clear one field at a time
    for (int f = 0; f < 4; f++) begin
      step(2'b11, 2'(f), '0, '0, 1'b0, '0, '0);
      compare_all("R6");
    end

    // R8: clear vs sticky on same and on different fields
    step(2'b00, 2'd0, '0, '0, 1'b1, 2'd1, 6'h0f);
    step(2'b11, 2'd1, '0, '0, 1'b1, 2'd1, 6'h3f);
    compare_all("R8");
    chk("R8", 32'(flg_o[6 +: 6]), 0);
    step(2'b11, 2'd2, '0, '0, 1'b1, 2'd1, 6'h0c);
    compare_all("R8");

    // R5: sweep every AND mask
    for (int i = 0; i < 128; i++) begin
      step(2'b10, 2'(i % 4), 7'(i), 7'((i * 37) & 7'h0a), 1'b0, '0, '0);
      compare_all("R5");
    end

    // R2/R3/R4 exhaustive on field 1, R9 pulse width
    for (int a = 0; a < 64; a++) begin
      for (int m = 0; m < 64; m++) begin
        logic [5:0] av, mv;
        logic exp;
        string req;
        av = 6'(a); mv = 6'(m);
        step(2'b11, 2'd0, '0, '0, 1'b0, '0, '0);
        step(2'b11, 2'd1, '0, '0, 1'b1, 2'd0, mv);
        step(2'b00, 2'd0, '0, '0, 1'b1, 2'd1, av);
        exp = (|(av & TR)) | (|(av & ~mv));
        req = (|(av & TR)) ? "R2" : ((|(av & ~mv)) ? "R3" : "R4");
        step(2'b01, 2'd1, '0, '0, 1'b0, '0, '0);
        chk(req, 32'(recover_o), 32'(exp));
        chk("R4", 32'(flg_o[6 +: 6]), 32'(av));
        step(2'b00, 2'd0, '0, '0, 1'b0, '0, '0);
        chk("R9", 32'(recover_o), 0);
      end
    end
    compare_all("R4");

    // other alternates, and check on the main field itself
    for (int f = 2; f < 4; f++) begin
      for (int a = 0; a < 64; a += 5) begin
        logic [5:0] mv;
        logic exp;
        mv = 6'(a * 11);
        step(2'b11, 2'd0, '0, '0, 1'b0, '0, '0);
        step(2'b11, 2'(f), '0, '0, 1'b1, 2'd0, mv);
        step(2'b00, 2'd0, '0, '0, 1'b1, 2'(f), 6'(a));
        exp = (|(6'(a) & TR)) | (|(6'(a) & ~mv));
        step(2'b01, 2'(f), '0, '0, 1'b0, '0, '0);
        chk("R3", 32'(recover_o), 32'(exp));
      end
    end
    for (int m = 0; m < 64; m++) begin
      step(2'b11, 2'd0, '0, '0, 1'b0, '0, '0);
      step(2'b00, 2'd0, '0, '0, 1'b1, 2'd0, 6'(m));
      step(2'b01, 2'd0, '0, '0, 1'b0, '0, '0);
      chk("R2", 32'(recover_o), 32'(|(6'(m) & TR)));
    end
    compare_all("R4");
    chk("R1", 32'(trap_o), 32'(TR));

    finish_run();
  end
endmodule